// File: doc/BRIEF.md
# Timer Shadow Register Load Controller

This block is a 16-bit timer counter whose three working values (start count, terminal count and one compare value) are each held twice: a write buffer that the bus writes, and an active copy that the counter and its compare logic use. A per-register load state machine decides on which clock edge the buffer is copied into the active copy. The choice depends on whether the counter clock is selected, on an enhanced-mode enable, on a center-aligned mode bit, on per-register synchronisation enables and on a single-cycle synchronisation pulse.

The counter is built in. It provides the load points. In edge-aligned mode it counts up from the start value to the terminal value and then returns to the start value; with start 0x0000 and terminal 0xFFFF this is the free-running roll from 0xFFFF to 0x0000. In center-aligned mode it counts up to the terminal value, turns, counts down to the start value and turns again.

Counter state machine: `CS_IDLE` (clock not selected, count held), `CS_UP` (rising), `CS_DOWN` (falling, center-aligned only). Transitions: any state goes to `CS_IDLE` when the clock select is 00. `CS_IDLE`/`CS_UP` go to `CS_DOWN` at the terminal value in center-aligned mode, and otherwise stay in or enter `CS_UP`. `CS_DOWN` goes to `CS_UP` at the start value, or at once if center-aligned mode is cleared. Load state machine (one per register): `SL_EMPTY` goes to `SL_PEND` on a write while the clock runs. `SL_PEND` returns to `SL_EMPTY` when its load trigger fires with no new write in the same cycle.

Top module: `tmr_shadow_ctrl`

## Requirements
- R1: While `clk_sel` is 00, a write puts the data into the active register on the same clock edge (visible one cycle after the write cycle), for all three registers and whatever `enh_en` is.
- R2: With the clock running and either `enh_en`=0 or `init_sync_en`=0, a start-value write reaches `init_val` one edge after the write edge (two cycles after the write cycle).
- R3: With the clock running and `enh_en`=1, `sync_mode`=1 and `init_sync_en`=1, a pending start value stays out of `init_val` until the cycle with `sync_pulse`=1. It loads on that edge.
- R4: With the clock running, `enh_en`=0 and `center_mode`=0, a pending terminal value loads on the edge where the count goes from the terminal value to the start value.
- R5: With start 0x0000 and terminal 0xFFFF, the count rolls from 0xFFFF to 0x0000, and a pending terminal value loads on that roll.
- R6: With `center_mode`=1 and `enh_en`=0, a pending terminal value loads on the edge where the count steps from the terminal value down to terminal-1.
- R7: With the clock running and `enh_en`=1, a pending terminal value loads only on a `sync_pulse` cycle.
- R8: With `enh_en`=0, the compare value uses the same load points as the terminal value. With `enh_en`=1 it loads on `sync_pulse` if `cmp_sync_en`=1, and otherwise one edge after the write edge.
- R9: The count holds while `clk_sel`=00. Edge-aligned mode counts up and wraps. Center-aligned mode counts up to the terminal value and down to the start value, with `cnt_down` high while falling.
- R10: One `sync_pulse` loads every pending register whose path is synchronised in the same cycle. A register with no pending write, or a write with `wr_sel`=3, leaves every active value unchanged.
- R11: After reset, every active value, the count and `cnt_down` are zero, and the counter is stopped.
- R12: Register select encoding: `wr_sel`=0 start value, 1 terminal value, 2 compare value, 3 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Counter clock select, 00 stops the counter |
| enh_en | input | 1 | Enhanced mode enable |
| center_mode | input | 1 | Center-aligned (up-down) counting |
| sync_mode | input | 1 | Synchronisation scheme select for the start value |
| init_sync_en | input | 1 | Start value loads by synchronisation |
| cmp_sync_en | input | 1 | Compare value loads by synchronisation |
| sync_pulse | input | 1 | Single-cycle synchronisation trigger |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| cnt_val | output | 16 | Current count |
| init_val | output | 16 | Active start value |
| mod_val | output | 16 | Active terminal value |
| cmp_val | output | 16 | Active compare value |
| cnt_down | output | 1 | Counter is in the falling half |

## Verification
Every output is a register. The count and any boundary or sync load are therefore seen one edge after the cycle that triggers them. A write when stopped appears one edge after the write cycle, and a next-clock load two edges after it. The bench drives inputs on the falling edge. It advances a cycle-accurate model right after each rising edge and compares all outputs at the next falling edge, so each result is checked in the exact cycle it is due. Directed checks of a deferred load first confirm the old value one cycle after the write, then confirm the new value at the boundary.

// File: rtl/tmr_shadow_pkg.sv
package tmr_shadow_pkg;

    localparam int NUM_SLOTS = 3;
    localparam int SLOT_INIT = 0;
    localparam int SLOT_MOD  = 1;
    localparam int SLOT_CMP  = 2;

    // How a pending buffer reaches its active copy while the clock runs
    typedef enum logic [1:0] {
        LP_NEXT = 2'd0,   // next edge
        LP_EDGE = 2'd1,   // counter boundary
        LP_SYNC = 2'd2    // synchronisation pulse
    } load_path_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_UP   = 2'd1,
        CS_DOWN = 2'd2
    } cnt_state_t;

    typedef enum logic {
        SL_EMPTY = 1'b0,
        SL_PEND  = 1'b1
    } slot_state_t;

endpackage

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_shadow_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         center,
    input  logic [W-1:0] init_v,
    input  logic [W-1:0] mod_v,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         bnd_evt
);

    cnt_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         at_mod, at_init, rising;

    assign at_mod  = (cnt_q == mod_v);
    assign at_init = (cnt_q == init_v);
    assign rising  = (state_q != CS_DOWN) || !center;

    // Next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CS_IDLE, CS_UP: begin
                if (!run) begin
                    state_d = CS_IDLE;
                end else if (center) begin
                    if (at_mod) begin
                        state_d = CS_DOWN;
                        cnt_d   = cnt_q - 1'b1;
                    end else begin
                        state_d = CS_UP;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end else begin
                    state_d = CS_UP;
                    cnt_d   = at_mod ? init_v : cnt_q + 1'b1;
                end
            end
            CS_DOWN: begin
                if (!run) begin
                    state_d = CS_IDLE;
                end else if (!center) begin
                    state_d = CS_UP;
                    cnt_d   = at_mod ? init_v : cnt_q + 1'b1;
                end else if (at_init) begin
                    state_d = CS_UP;
                    cnt_d   = cnt_q + 1'b1;
                end else begin
                    state_d = CS_DOWN;
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = CS_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        cnt     = cnt_q;
        down    = (state_q == CS_DOWN);
        bnd_evt = run && at_mod && rising;
    end

    // R9: a stopped counter keeps its value
    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == $past(cnt_q));

    // R4: edge-aligned wrap returns to the start value
    assert_wrap_to_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !center && at_mod) |=> cnt_q == $past(init_v));

    // R6: center-aligned turn at the terminal value goes down by one
    assert_turn_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && center && rising && at_mod) |=> (down && cnt_q == $past(cnt_q) - 1'b1));

    // R9: leaving the falling half at the start value
    assert_turn_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && center && !rising && at_init) |=> !down);

endmodule

// File: rtl/tmr_shadow_slot.sv
module tmr_shadow_slot
    import tmr_shadow_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stopped,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  load_path_t   path,
    input  logic         bnd_evt,
    input  logic         sync_pulse,
    output logic [W-1:0] act
);

    slot_state_t  state_q, state_d;
    logic [W-1:0] hold_q, hold_d;
    logic [W-1:0] act_q, act_d;
    logic         trig;

    always_comb begin
        unique case (path)
            LP_NEXT: trig = 1'b1;
            LP_EDGE: trig = bnd_evt;
            LP_SYNC: trig = sync_pulse;
            default: trig = 1'b0;
        endcase
        trig = trig || stopped;
    end

    // Next state, buffer and active copy
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        act_d   = act_q;
        unique case (state_q)
            SL_EMPTY: begin
                if (wr) begin
                    hold_d = wr_data;
                    if (stopped) begin
                        act_d = wr_data;
                    end else begin
                        state_d = SL_PEND;
                    end
                end
            end
            SL_PEND: begin
                if (trig) begin
                    act_d = hold_q;
                end
                if (wr) begin
                    hold_d = wr_data;
                    if (stopped) begin
                        act_d   = wr_data;
                        state_d = SL_EMPTY;
                    end
                end else if (trig) begin
                    state_d = SL_EMPTY;
                end
            end
            default: begin
                state_d = SL_EMPTY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SL_EMPTY;
            hold_q  <= '0;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            act_q   <= act_d;
        end
    end

    // Outputs
    always_comb begin
        act = act_q;
    end

    // R1: a write while stopped is active one edge later
    assert_stopped_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wr) |=> act_q == $past(wr_data));

    // R10: nothing pending and nothing written keeps the active copy
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_EMPTY && !wr) |=> $stable(act_q));

    // R3 and R7: a synchronised path only moves on a pulse
    assert_sync_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (path == LP_SYNC && !sync_pulse && !stopped) |=> $stable(act_q));

    // R4: an edge path only moves at a counter boundary
    assert_edge_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (path == LP_EDGE && !bnd_evt && !stopped) |=> $stable(act_q));

endmodule

// File: rtl/tmr_shadow_ctrl.sv
module tmr_shadow_ctrl
    import tmr_shadow_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   clk_sel,
    input  logic         enh_en,
    input  logic         center_mode,
    input  logic         sync_mode,
    input  logic         init_sync_en,
    input  logic         cmp_sync_en,
    input  logic         sync_pulse,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_val,
    output logic [W-1:0] init_val,
    output logic [W-1:0] mod_val,
    output logic [W-1:0] cmp_val,
    output logic         cnt_down
);

    localparam int SELW = 2;

    logic         run;
    logic         bnd_evt;
    logic [W-1:0] act_arr [NUM_SLOTS];
    load_path_t   path_arr [NUM_SLOTS];

    assign run = (clk_sel != 2'b00);

    // Path decode per register
    always_comb begin
        path_arr[SLOT_INIT] = (enh_en && sync_mode && init_sync_en) ? LP_SYNC : LP_NEXT;
        path_arr[SLOT_MOD]  = enh_en ? LP_SYNC : LP_EDGE;
        if (!enh_en) begin
            path_arr[SLOT_CMP] = LP_EDGE;
        end else begin
            path_arr[SLOT_CMP] = cmp_sync_en ? LP_SYNC : LP_NEXT;
        end
    end

    tmr_cnt_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .center  (center_mode),
        .init_v  (act_arr[SLOT_INIT]),
        .mod_v   (act_arr[SLOT_MOD]),
        .cnt     (cnt_val),
        .down    (cnt_down),
        .bnd_evt (bnd_evt)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        tmr_shadow_slot #(.W(W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .stopped    (!run),
            .wr         (wr_en && (wr_sel == SELW'(g))),
            .wr_data    (wr_data),
            .path       (path_arr[g]),
            .bnd_evt    (bnd_evt),
            .sync_pulse (sync_pulse),
            .act        (act_arr[g])
        );
    end

    assign init_val = act_arr[SLOT_INIT];
    assign mod_val  = act_arr[SLOT_MOD];
    assign cmp_val  = act_arr[SLOT_CMP];

    // R12: select 3 writes no register
    assert_no_sel3_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !sync_pulse && !bnd_evt && run && !enh_en)
        |=> $stable(mod_val) && $stable(cmp_val));

endmodule

// File: tb/tmr_shadow_ctrl_test.sv
module tmr_shadow_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   clk_sel = 2'b00;
    logic         enh_en = 1'b0, center_mode = 1'b0, sync_mode = 1'b0;
    logic         init_sync_en = 1'b0, cmp_sync_en = 1'b0, sync_pulse = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_val, init_val, mod_val, cmp_val;
    logic         cnt_down;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Model state
    logic [W-1:0] m_cnt = '0;
    logic         m_down = 1'b0;
    logic [W-1:0] m_act  [3] = '{default: '0};
    logic [W-1:0] m_hold [3] = '{default: '0};
    logic         m_pend [3] = '{default: 1'b0};

    tmr_shadow_ctrl #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .enh_en(enh_en),
        .center_mode(center_mode), .sync_mode(sync_mode),
        .init_sync_en(init_sync_en), .cmp_sync_en(cmp_sync_en),
        .sync_pulse(sync_pulse), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_val(cnt_val), .init_val(init_val),
        .mod_val(mod_val), .cmp_val(cmp_val), .cnt_down(cnt_down)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 180000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=180000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // 0 next edge, 1 counter boundary, 2 sync pulse (R2, R3, R7, R8)
    function automatic int path_of(int slot);
        if (slot == 0) return (enh_en && sync_mode && init_sync_en) ? 2 : 0;
        if (slot == 1) return enh_en ? 2 : 1;
        if (!enh_en) return 1;
        return cmp_sync_en ? 2 : 0;
    endfunction

    function automatic logic [W-1:0] up_next(logic [W-1:0] c, logic [W-1:0] ini, logic [W-1:0] md);
        return (c == md) ? ini : c + 1'b1;
    endfunction

    task automatic model_step();
        logic run, bnd, trig;
        logic [W-1:0] n_cnt;
        logic n_down;
        run = (clk_sel != 2'b00);
        bnd = run && (m_cnt == m_act[1]) && (!m_down || !center_mode);
        n_cnt = m_cnt;
        n_down = 1'b0;
        if (run) begin
            if (!center_mode) begin
                n_cnt = up_next(m_cnt, m_act[0], m_act[1]);
            end else if (!m_down) begin
                if (m_cnt == m_act[1]) begin n_cnt = m_cnt - 1'b1; n_down = 1'b1; end
                else n_cnt = m_cnt + 1'b1;
            end else begin
                if (m_cnt == m_act[0]) n_cnt = m_cnt + 1'b1;
                else begin n_cnt = m_cnt - 1'b1; n_down = 1'b1; end
            end
        end
        for (int s = 0; s < 3; s++) begin
            int p;
            logic w;
            p = path_of(s);
            trig = !run || p == 0 || (p == 1 && bnd) || (p == 2 && sync_pulse);
            w = wr_en && (wr_sel == 2'(s));
            if (m_pend[s] && trig) m_act[s] = m_hold[s];
            if (w) begin
                m_hold[s] = wr_data;
                if (!run) begin m_act[s] = wr_data; m_pend[s] = 1'b0; end
                else m_pend[s] = 1'b1;
            end else if (m_pend[s] && trig) begin
                m_pend[s] = 1'b0;
            end
        end
        m_cnt = n_cnt;
        m_down = n_down;
    endtask

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " cnt_val"}, cnt_val, m_cnt);
        chk({tag, " cnt_down"}, {15'd0, cnt_down}, {15'd0, m_down});
        chk({tag, " init_val"}, init_val, m_act[0]);
        chk({tag, " mod_val"}, mod_val, m_act[1]);
        chk({tag, " cmp_val"}, cmp_val, m_act[2]);
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        wr_en = 1'b0;
        sync_pulse = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, logic [W-1:0] d, string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 cnt_val", cnt_val, 16'h0);
        chk("R11 init_val", init_val, 16'h0);
        chk("R11 mod_val", mod_val, 16'h0);
        chk("R11 cmp_val", cmp_val, 16'h0);
        chk("R11 cnt_down", {15'd0, cnt_down}, 16'h0);

        // R1 and R12: writes while stopped land at once
        wr(2'd0, 16'd2, "R1");
        chk("R1 init immediate", init_val, 16'd2);
        wr(2'd1, 16'd7, "R1");
        chk("R1 mod immediate", mod_val, 16'd7);
        enh_en = 1'b1;
        wr(2'd2, 16'd4, "R1");
        chk("R12 cmp immediate with enh", cmp_val, 16'd4);
        enh_en = 1'b0;

        // R9: edge-aligned counting
        clk_sel = 2'b01;
        tick("R9");
        chk("R9 first count", cnt_val, 16'd1);
        repeat (8) tick("R9");

        // R4: terminal value deferred to the wrap
        wr(2'd1, 16'd5, "R4");
        chk("R4 mod held", mod_val, 16'd7);
        repeat (12) tick("R4");
        chk("R4 mod after wrap", mod_val, 16'd5);

        // R2: start value one edge after the write edge
        wr(2'd0, 16'd1, "R2");
        chk("R2 init not yet", init_val, 16'd2);
        tick("R2");
        chk("R2 init loaded", init_val, 16'd1);

        // R8: compare uses the boundary when enh_en=0
        wr(2'd2, 16'd9, "R8");
        chk("R8 cmp held", cmp_val, 16'd4);
        repeat (10) tick("R8");
        chk("R8 cmp at boundary", cmp_val, 16'd9);

        // R6: center-aligned turn load
        center_mode = 1'b1;
        repeat (3) tick("R9 center");
        wr(2'd1, 16'd8, "R6");
        repeat (30) tick("R6");
        chk("R6 mod after turn", mod_val, 16'd8);

        // R3, R7, R10: synchronised loads
        center_mode = 1'b0;
        enh_en = 1'b1; sync_mode = 1'b1; init_sync_en = 1'b1; cmp_sync_en = 1'b1;
        wr(2'd0, 16'd3, "R3");
        wr(2'd1, 16'd12, "R7");
        wr(2'd2, 16'd6, "R10");
        repeat (20) tick("R7");
        chk("R3 init waits", init_val, 16'd1);
        chk("R7 mod waits", mod_val, 16'd8);
        sync_pulse = 1'b1;
        tick("R10");
        chk("R3 init on pulse", init_val, 16'd3);
        chk("R7 mod on pulse", mod_val, 16'd12);
        chk("R10 cmp same pulse", cmp_val, 16'd6);

        // R8: enhanced, compare not synchronised
        cmp_sync_en = 1'b0;
        wr(2'd2, 16'd2, "R8");
        tick("R8");
        chk("R8 cmp next edge", cmp_val, 16'd2);

        // R10 and R12: select 3 and a bare pulse change nothing
        wr(2'd3, 16'h5555, "R12");
        sync_pulse = 1'b1;
        tick("R10");
        chk("R12 init unchanged", init_val, 16'd3);
        chk("R12 mod unchanged", mod_val, 16'd12);
        chk("R12 cmp unchanged", cmp_val, 16'd2);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 150 == 0) begin
                clk_sel = ($urandom % 8 == 0) ? 2'b00 : 2'($urandom % 3 + 1);
                enh_en = 1'($urandom); center_mode = 1'($urandom);
                sync_mode = 1'($urandom); init_sync_en = 1'($urandom);
                cmp_sync_en = 1'($urandom);
            end
            if ($urandom % 10 == 0) begin
                int s;
                s = $urandom % 4;
                wr_en = 1'b1; wr_sel = 2'(s);
                wr_data = (s == 0) ? W'($urandom % 4) :
                          (s == 1) ? W'($urandom % 15 + 6) : W'($urandom % 21);
            end
            sync_pulse = ($urandom % 25 == 0);
            tick("R10 random");
        end

        // R5: free-running roll
        clk_sel = 2'b00; enh_en = 1'b0; center_mode = 1'b0;
        wr(2'd0, 16'h0000, "R5");
        wr(2'd1, 16'hFFFF, "R5");
        tick("R9 stop");
        clk_sel = 2'b01;
        wr(2'd1, 16'd10, "R5");
        for (int k = 0; k < 70000 && cnt_val != 16'hFFFF; k++) tick("R5");
        chk("R5 at top", cnt_val, 16'hFFFF);
        chk("R5 mod held", mod_val, 16'hFFFF);
        tick("R5");
        chk("R5 rolled", cnt_val, 16'h0000);
        chk("R5 mod on roll", mod_val, 16'd10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule